// File: doc/BRIEF.md
# Interrupt Gate Descriptor Fetch Unit

This block turns an interrupt or exception vector number into the decoded gate descriptor for that vector. The descriptor table lives in ordinary memory. A base address and a byte limit, both supplied on input ports, say where the table is and how long it is. Each vector owns one 8-byte slot. The block works out the slot address and checks that the whole slot lies inside the limit. It then reads the slot as two 32-bit words over a request/response read port.

Once both words are in, the block classifies the gate as a task gate, an interrupt gate or a trap gate. For an interrupt or trap gate it returns the handler segment selector and the 32-bit handler offset. For a task gate it returns the task-state selector. It also returns the maskable-interrupt enable flag as it stands after the gate is taken: an interrupt gate clears the flag, and the other gates leave it unchanged.

A limit violation, an unknown type code or a descriptor that is marked not present is reported on one error line. The error line pulses together with the completion pulse. Privilege checks, stack switching and frame pushing belong to neighbouring logic.

Top module: `gate_fetch_unit`

## Requirements
- R1: The low descriptor word is read from address base + vector×8, and after it the high word is read from that address + 4. Exactly two reads are made for an entry that lies inside the limit.
- R2: If vector×8+7 is greater than the limit, `done` and `err` pulse in the cycle after the request is accepted and no read is issued.
- R3: While `rd_valid` is high and `rd_ready` is low, `rd_valid` stays high and `rd_addr` holds its value in the next cycle.
- R4: `done` is high for exactly one cycle, and that cycle is the one right after the cycle in which the high-word response arrives.
- R5: Descriptor bits 43..40 give the gate kind. 0101 is a task gate (`gate_kind` 01), 1110 is an interrupt gate (10) and 1111 is a trap gate (11). Any other code sets `err`.
- R6: A descriptor whose present bit (bit 47) is 0 sets `err`.
- R7: For interrupt and trap gates, `gate_sel` is descriptor bits 31..16. `gate_off` is bits 63..48 followed by bits 15..0.
- R8: For a task gate, `gate_sel` is descriptor bits 31..16 (the task-state selector) and `gate_off` is 0.
- R9: `if_out` is 0 after an interrupt gate. After a trap gate, a task gate or any error it equals `if_in` as sampled when the request was accepted.
- R10: A request is accepted only while `req_ready` is high. `req_ready` is high only when no fetch is in progress, and a request raised at any other time is ignored.
- R11: A synchronous reset returns the block to idle, with `req_ready` at 1, no read outstanding, and `done`, `err`, `gate_kind`, `gate_sel`, `gate_off` and `if_out` all at 0.
- R12: Whenever `err` is reported, `gate_kind`, `gate_sel` and `gate_off` are 0.
- R13: `gate_kind`, `gate_sel`, `gate_off` and `if_out` keep their values between completion pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Vector lookup request |
| req_vector | input | VEC_W | Vector number to look up |
| req_ready | output | 1 | Block is idle and can take a request |
| tbl_base | input | ADDR_W | Byte address of table entry 0 |
| tbl_limit | input | LIMIT_W | Highest valid byte offset in the table |
| if_in | input | 1 | Current maskable-interrupt enable flag |
| rd_valid | output | 1 | Memory read request |
| rd_addr | output | ADDR_W | Byte address of the word to read |
| rd_ready | input | 1 | Memory accepts the read request |
| rsp_valid | input | 1 | Read data is valid |
| rsp_data | input | 32 | Read data word |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Fault, valid together with `done` |
| gate_kind | output | 2 | 00 none, 01 task, 10 interrupt, 11 trap |
| gate_sel | output | 16 | Handler selector or task-state selector |
| gate_off | output | 32 | Handler offset (0 for a task gate) |
| if_out | output | 1 | Interrupt-enable flag after taking the gate |

## Verification
The bench uses the default widths: 32-bit addresses, 8-bit vectors and a 16-bit limit. With 8-bit vectors all 256 slots can be addressed, up to vector 255 at the 2047-byte end of a full table. The 16-bit limit is wider than the 11-bit slot end, so the limit comparison takes its wide variant. A limit can also be set to any value on either side of a slot's last byte, which covers both the exact-fit case and the one-byte-short case. The memory model can throttle `rd_ready`, and it can move the table to a second base address.

// File: rtl/gfu_pkg.sv
package gfu_pkg;

   localparam int WORD_W      = 32;
   localparam int DESC_W      = 2 * WORD_W;
   localparam int TYPE_LSB    = 40;
   localparam int PRESENT_BIT = 47;
   localparam int SEL_LSB     = 16;
   localparam int OFF_HI_LSB  = 48;

   localparam logic [3:0] TY_TASK = 4'b0101;
   localparam logic [3:0] TY_INTR = 4'b1110;
   localparam logic [3:0] TY_TRAP = 4'b1111;

   typedef enum logic [1:0] {
      GK_NONE = 2'b00,
      GK_TASK = 2'b01,
      GK_INTR = 2'b10,
      GK_TRAP = 2'b11
   } gate_kind_e;

   typedef enum logic [2:0] {
      FS_IDLE,
      FS_LO_REQ,
      FS_LO_WAIT,
      FS_HI_REQ,
      FS_HI_WAIT
   } fetch_state_e;

   typedef struct packed {
      gate_kind_e  kind;
      logic        fault;
      logic [15:0] sel;
      logic [31:0] off;
      logic        clr_if;
   } gate_info_t;

endpackage

// File: rtl/gfu_entry_locate.sv
module gfu_entry_locate #(
   parameter int ADDR_W  = 32,
   parameter int VEC_W   = 8,
   parameter int LIMIT_W = 16
) (
   input  logic [ADDR_W-1:0]  base,
   input  logic [LIMIT_W-1:0] limit,
   input  logic [VEC_W-1:0]   vector,
   output logic [ADDR_W-1:0]  entry_addr,
   output logic               in_range
);
   localparam int END_W = VEC_W + 3;

   logic [END_W-1:0] first_byte;
   logic [END_W-1:0] last_byte;

   assign first_byte = {vector, 3'b000};
   assign last_byte  = {vector, 3'b111};
   assign entry_addr = base + ADDR_W'(first_byte);

   generate
      if (LIMIT_W >= END_W) begin : g_wide_limit
         logic [LIMIT_W-1:0] last_ext;
         assign last_ext = LIMIT_W'(last_byte);
         assign in_range = (last_ext <= limit);
      end else begin : g_narrow_limit
         assign in_range = (last_byte[END_W-1:LIMIT_W] == '0) &&
                           (last_byte[LIMIT_W-1:0] <= limit);
      end
   endgenerate

endmodule

// File: rtl/gfu_fetch_seq.sv
module gfu_fetch_seq
   import gfu_pkg::*;
#(
   parameter int ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              start,
   input  logic [ADDR_W-1:0] start_addr,
   input  logic              rd_ready,
   input  logic              rsp_valid,
   input  logic [WORD_W-1:0] rsp_data,
   output logic              idle,
   output logic              rd_valid,
   output logic [ADDR_W-1:0] rd_addr,
   output logic              desc_valid,
   output logic [DESC_W-1:0] desc
);
   localparam logic [ADDR_W-1:0] HI_STEP = ADDR_W'(WORD_W / 8);

   fetch_state_e      state;
   logic [ADDR_W-1:0] addr_q;
   logic [WORD_W-1:0] lo_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         state  <= FS_IDLE;
         addr_q <= '0;
         lo_q   <= '0;
      end else begin
         unique case (state)
            FS_IDLE: begin
               if (start) begin
                  addr_q <= start_addr;
                  state  <= FS_LO_REQ;
               end
            end
            FS_LO_REQ: begin
               if (rd_ready) state <= FS_LO_WAIT;
            end
            FS_LO_WAIT: begin
               if (rsp_valid) begin
                  lo_q  <= rsp_data;
                  state <= FS_HI_REQ;
               end
            end
            FS_HI_REQ: begin
               if (rd_ready) state <= FS_HI_WAIT;
            end
            FS_HI_WAIT: begin
               if (rsp_valid) state <= FS_IDLE;
            end
            default: state <= FS_IDLE;
         endcase
      end
   end

   always_comb begin
      idle       = (state == FS_IDLE);
      rd_valid   = (state == FS_LO_REQ) || (state == FS_HI_REQ);
      rd_addr    = (state == FS_HI_REQ) ? (addr_q + HI_STEP) : addr_q;
      desc_valid = (state == FS_HI_WAIT) && rsp_valid;
      desc       = {rsp_data, lo_q};
   end

endmodule

// File: rtl/gfu_gate_decode.sv
module gfu_gate_decode
   import gfu_pkg::*;
(
   input  logic [DESC_W-1:0] desc,
   output gate_info_t        info
);
   logic [3:0]  type_code;
   logic        present;
   gate_kind_e  kind;
   logic        unused_rsvd;

   assign type_code   = desc[TYPE_LSB +: 4];
   assign present     = desc[PRESENT_BIT];
   assign unused_rsvd = ^{desc[TYPE_LSB-1:SEL_LSB+16], desc[PRESENT_BIT-1:TYPE_LSB+4]};

   always_comb begin
      unique case (type_code)
         TY_TASK: kind = GK_TASK;
         TY_INTR: kind = GK_INTR;
         TY_TRAP: kind = GK_TRAP;
         default: kind = GK_NONE;
      endcase
   end

   always_comb begin
      info        = '0;
      info.fault  = !present || (kind == GK_NONE);
      if (!info.fault) begin
         info.kind   = kind;
         info.sel    = desc[SEL_LSB +: 16];
         info.clr_if = (kind == GK_INTR);
         if (kind != GK_TASK) begin
            info.off = {desc[OFF_HI_LSB +: 16], desc[15:0]};
         end
      end
   end

endmodule

// File: rtl/gate_fetch_unit.sv
module gate_fetch_unit
   import gfu_pkg::*;
#(
   parameter int ADDR_W  = 32,
   parameter int VEC_W   = 8,
   parameter int LIMIT_W = 16
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               req_valid,
   input  logic [VEC_W-1:0]   req_vector,
   output logic               req_ready,
   input  logic [ADDR_W-1:0]  tbl_base,
   input  logic [LIMIT_W-1:0] tbl_limit,
   input  logic               if_in,
   output logic               rd_valid,
   output logic [ADDR_W-1:0]  rd_addr,
   input  logic               rd_ready,
   input  logic               rsp_valid,
   input  logic [31:0]        rsp_data,
   output logic               done,
   output logic               err,
   output logic [1:0]         gate_kind,
   output logic [15:0]        gate_sel,
   output logic [31:0]        gate_off,
   output logic               if_out
);
   generate
      if (VEC_W < 1 || VEC_W > 8) begin : g_bad_vec_w
         $error("gate_fetch_unit: VEC_W must lie in 1..8");
      end
      if (ADDR_W < VEC_W + 3 || ADDR_W > 64) begin : g_bad_addr_w
         $error("gate_fetch_unit: ADDR_W must cover the table and not exceed 64");
      end
      if (LIMIT_W < 3) begin : g_bad_limit_w
         $error("gate_fetch_unit: LIMIT_W must be at least 3");
      end
   endgenerate

   logic [ADDR_W-1:0] entry_addr;
   logic              in_range;
   logic              seq_idle;
   logic              desc_valid;
   logic [DESC_W-1:0] desc;
   gate_info_t        info;
   logic              accept;
   logic              if_q;

   gfu_entry_locate #(
      .ADDR_W (ADDR_W),
      .VEC_W  (VEC_W),
      .LIMIT_W(LIMIT_W)
   ) u_locate (
      .base      (tbl_base),
      .limit     (tbl_limit),
      .vector    (req_vector),
      .entry_addr(entry_addr),
      .in_range  (in_range)
   );

   gfu_fetch_seq #(
      .ADDR_W(ADDR_W)
   ) u_seq (
      .clk       (clk),
      .rst       (rst),
      .start     (accept && in_range),
      .start_addr(entry_addr),
      .rd_ready  (rd_ready),
      .rsp_valid (rsp_valid),
      .rsp_data  (rsp_data),
      .idle      (seq_idle),
      .rd_valid  (rd_valid),
      .rd_addr   (rd_addr),
      .desc_valid(desc_valid),
      .desc      (desc)
   );

   gfu_gate_decode u_decode (
      .desc(desc),
      .info(info)
   );

   assign req_ready = seq_idle;
   assign accept    = req_valid && req_ready;

   always_ff @(posedge clk) begin
      if (rst) begin
         done      <= 1'b0;
         err       <= 1'b0;
         gate_kind <= '0;
         gate_sel  <= '0;
         gate_off  <= '0;
         if_out    <= 1'b0;
         if_q      <= 1'b0;
      end else begin
         done <= 1'b0;
         err  <= 1'b0;
         if (accept) begin
            if_q <= if_in;
         end
         if (accept && !in_range) begin
            done      <= 1'b1;
            err       <= 1'b1;
            gate_kind <= GK_NONE;
            gate_sel  <= '0;
            gate_off  <= '0;
            if_out    <= if_in;
         end else if (desc_valid) begin
            done      <= 1'b1;
            err       <= info.fault;
            gate_kind <= info.kind;
            gate_sel  <= info.sel;
            gate_off  <= info.off;
            if_out    <= info.clr_if ? 1'b0 : if_q;
         end
      end
   end

endmodule

// File: rtl/gfu_chk.sv
module gfu_chk #(
   parameter int ADDR_W = 32
) (
   input logic              clk,
   input logic              rst,
   input logic              req_ready,
   input logic              rd_valid,
   input logic [ADDR_W-1:0] rd_addr,
   input logic              rd_ready,
   input logic              done,
   input logic              err,
   input logic [1:0]        gate_kind,
   input logic [15:0]       gate_sel,
   input logic [31:0]       gate_off,
   input logic              if_out
);
   p_ready_excl_r10: assert property (@(posedge clk) disable iff (rst)
      req_ready |-> !rd_valid);

   p_rd_hold_r3: assert property (@(posedge clk) disable iff (rst)
      (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_addr)));

   p_done_pulse_r4: assert property (@(posedge clk) disable iff (rst)
      done |=> !done);

   p_intr_clears_r9: assert property (@(posedge clk) disable iff (rst)
      (done && !err && gate_kind == 2'b10) |-> !if_out);

   p_err_zero_r12: assert property (@(posedge clk) disable iff (rst)
      (done && err) |-> (gate_kind == 2'b00 && gate_sel == 16'h0 && gate_off == 32'h0));

   p_hold_r13: assert property (@(posedge clk) disable iff (rst)
      (!done && !$past(rst)) |-> ($stable(gate_kind) && $stable(gate_sel) &&
                                  $stable(gate_off) && $stable(if_out)));

   p_reset_clear_r11: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (req_ready && !rd_valid && !done && !err &&
                      gate_kind == 2'b00 && gate_sel == 16'h0 &&
                      gate_off == 32'h0 && !if_out));

endmodule

bind gate_fetch_unit gfu_chk #(
   .ADDR_W(ADDR_W)
) u_chk (
   .clk      (clk),
   .rst      (rst),
   .req_ready(req_ready),
   .rd_valid (rd_valid),
   .rd_addr  (rd_addr),
   .rd_ready (rd_ready),
   .done     (done),
   .err      (err),
   .gate_kind(gate_kind),
   .gate_sel (gate_sel),
   .gate_off (gate_off),
   .if_out   (if_out)
);

// File: tb/gate_fetch_unit_test.sv
module gate_fetch_unit_test;
   localparam int ADDR_W  = 32;
   localparam int VEC_W   = 8;
   localparam int LIMIT_W = 16;
   localparam logic [31:0] BASE_A = 32'h0010_2000;
   localparam logic [31:0] BASE_B = 32'h0000_8000;

   // {vector[31:24], limit[23:8], if_in[7], stall[6], pad[5:0]}
   localparam int N_STIM = 13;
   localparam logic [31:0] STIM [0:N_STIM-1] = '{
      {8'd0,   16'h07FF, 1'b1, 1'b0, 6'd0},
      {8'd1,   16'h07FF, 1'b1, 1'b0, 6'd0},
      {8'd2,   16'h07FF, 1'b1, 1'b1, 6'd0},
      {8'd3,   16'h07FF, 1'b1, 1'b0, 6'd0},
      {8'd6,   16'h07FF, 1'b1, 1'b0, 6'd0},
      {8'd13,  16'h07FF, 1'b1, 1'b1, 6'd0},
      {8'd33,  16'h07FF, 1'b0, 1'b1, 6'd0},
      {8'd34,  16'h07FF, 1'b0, 1'b0, 6'd0},
      {8'd64,  16'h07FF, 1'b0, 1'b1, 6'd0},
      {8'd255, 16'h07FF, 1'b1, 1'b0, 6'd0},
      {8'd32,  16'h0107, 1'b1, 1'b0, 6'd0},
      {8'd33,  16'h0107, 1'b1, 1'b0, 6'd0},
      {8'd200, 16'h00FF, 1'b0, 1'b0, 6'd0}
   };

   logic               clk = 1'b0;
   logic               rst = 1'b1;
   logic               req_valid = 1'b0;
   logic [VEC_W-1:0]   req_vector = '0;
   logic               req_ready;
   logic [ADDR_W-1:0]  tbl_base = BASE_A;
   logic [LIMIT_W-1:0] tbl_limit = '0;
   logic               if_in = 1'b0;
   logic               rd_valid;
   logic [ADDR_W-1:0]  rd_addr;
   logic               rd_ready = 1'b1;
   logic               rsp_valid = 1'b0;
   logic [31:0]        rsp_data = '0;
   logic               done;
   logic               err;
   logic [1:0]         gate_kind;
   logic [15:0]        gate_sel;
   logic [31:0]        gate_off;
   logic               if_out;

   always #2 clk = ~clk;

   gate_fetch_unit #(.ADDR_W(ADDR_W), .VEC_W(VEC_W), .LIMIT_W(LIMIT_W)) uut (
      .clk(clk), .rst(rst), .req_valid(req_valid), .req_vector(req_vector),
      .req_ready(req_ready), .tbl_base(tbl_base), .tbl_limit(tbl_limit),
      .if_in(if_in), .rd_valid(rd_valid), .rd_addr(rd_addr), .rd_ready(rd_ready),
      .rsp_valid(rsp_valid), .rsp_data(rsp_data), .done(done), .err(err),
      .gate_kind(gate_kind), .gate_sel(gate_sel), .gate_off(gate_off), .if_out(if_out)
   );

   int nchk = 0;
   int nfail = 0;
   logic [31:0] mem_w [0:511];
   logic [31:0] cur_base = BASE_A;
   logic        stall_en = 1'b0;
   int          cyc = 0;
   logic        pend = 1'b0;
   logic [31:0] pend_addr = '0;
   int          rd_count = 0;
   logic [31:0] rd_log [0:1];
   int          last_rsp_cyc = 0;
   int          done_cyc = 0;
   int          done_cnt = 0;

   function automatic logic [63:0] desc_of(int v);
      logic [15:0] sel;
      logic [31:0] off;
      logic [3:0]  ty;
      logic        p;
      sel = {8'(v), 8'(v * 3 + 1)};
      off = {8'(v ^ 8'h5A), 8'(~v), 8'(v + 7), 8'(v)};
      case (v % 4)
         0: ty = 4'b0101;
         1: ty = 4'b1110;
         2: ty = 4'b1111;
         default: ty = 4'b1100;
      endcase
      p = !((v % 16) == 6 || (v % 16) == 13);
      return {off[31:16], p, 2'b00, 1'b0, ty, 8'h00, sel, off[15:0]};
   endfunction

   task automatic check(input logic ok, input string req, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
   endtask

   // memory model: accepts reads per rd_ready, answers one cycle later
   initial begin
      forever begin
         @(negedge clk);
         cyc++;
         if (done) begin
            done_cyc = cyc;
            done_cnt++;
         end
         rd_ready  = stall_en ? cyc[0] : 1'b1;
         rsp_valid = pend && !rst;
         if (pend) begin
            rsp_data = (((pend_addr - cur_base) >> 2) < 512) ?
                       mem_w[(pend_addr - cur_base) >> 2] : 32'hBAD0BAD0;
            last_rsp_cyc = cyc;
         end
         pend = !rst && rd_valid && rd_ready;
         if (pend) begin
            pend_addr = rd_addr;
            if (rd_count < 2) rd_log[rd_count] = rd_addr;
            rd_count++;
         end
      end
   end

   initial begin
      repeat (50000) @(posedge clk);
      nchk++;
      nfail++;
      $display("FAIL watchdog: actual hung expected completion");
      finish_run();
   end

   task automatic run_one(input int v, input logic [15:0] lim, input logic ifin,
                          input logic stall, input logic [31:0] base);
      logic [63:0] d;
      logic        in_rng, e_err, e_if;
      logic [1:0]  e_kind;
      logic [15:0] e_sel;
      logic [31:0] e_off;
      int          waited;
      @(negedge clk);
      cur_base = base; tbl_base = base; stall_en = stall;
      rd_count = 0; done_cnt = 0;
      req_vector = VEC_W'(v); tbl_limit = lim; if_in = ifin; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      if_in = ~ifin;
      waited = 0;
      while (!done && waited < 60) begin
         @(negedge clk);
         waited++;
      end
      d = desc_of(v);
      in_rng = (v * 8 + 7) <= int'(lim);
      case (d[43:40])
         4'b0101: e_kind = 2'b01;
         4'b1110: e_kind = 2'b10;
         4'b1111: e_kind = 2'b11;
         default: e_kind = 2'b00;
      endcase
      e_err = !in_rng || !d[47] || e_kind == 2'b00;
      e_if  = ifin;
      e_sel = '0;
      e_off = '0;
      if (e_err) e_kind = 2'b00;
      else begin
         e_sel = d[31:16];
         if (e_kind != 2'b01) e_off = {d[63:48], d[15:0]};
         if (e_kind == 2'b10) e_if = 1'b0;
      end
      check(done === 1'b1, "R4", "done seen", 64'(done), 64'd1);
      check(err === e_err, "R5 R6 R2", "err", 64'(err), 64'(e_err));
      check(gate_kind === e_kind, "R5 R12", "gate_kind", 64'(gate_kind), 64'(e_kind));
      check(gate_sel === e_sel, (e_kind == 2'b01) ? "R8" : "R7", "gate_sel",
            64'(gate_sel), 64'(e_sel));
      check(gate_off === e_off, (e_kind == 2'b01) ? "R8" : "R7", "gate_off",
            64'(gate_off), 64'(e_off));
      check(if_out === e_if, "R9", "if_out", 64'(if_out), 64'(e_if));
      if (!in_rng) begin
         check(waited == 0, "R2", "fault latency", 64'(waited), 64'd0);
         check(rd_count == 0, "R2", "reads on fault", 64'(rd_count), 64'd0);
      end else begin
         check(rd_count == 2, "R1", "read count", 64'(rd_count), 64'd2);
         check(rd_log[0] === base + 32'(v * 8), "R1", "low word address",
               64'(rd_log[0]), 64'(base + 32'(v * 8)));
         check(rd_log[1] === base + 32'(v * 8 + 4), "R1", "high word address",
               64'(rd_log[1]), 64'(base + 32'(v * 8 + 4)));
         check(done_cyc == last_rsp_cyc + 1, "R4", "done after high word",
               64'(done_cyc), 64'(last_rsp_cyc + 1));
      end
      @(negedge clk);
      check(done === 1'b0, "R4", "done single cycle", 64'(done), 64'd0);
      stall_en = 1'b0;
   endtask

   initial begin
      logic [15:0] s_sel;
      logic [31:0] s_off;
      logic [1:0]  s_kind;
      logic        s_if;
      for (int v = 0; v < 256; v++) begin
         logic [63:0] d;
         d = desc_of(v);
         mem_w[2 * v]     = d[31:0];
         mem_w[2 * v + 1] = d[63:32];
      end
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      // R11: reset state
      check(req_ready === 1'b1, "R11", "req_ready after reset", 64'(req_ready), 64'd1);
      check(rd_valid === 1'b0, "R11", "rd_valid after reset", 64'(rd_valid), 64'd0);
      check({done, err, gate_kind, gate_sel, gate_off, if_out} === '0, "R11",
            "outputs after reset", 64'({done, err, gate_kind, gate_sel, gate_off, if_out}), 64'd0);

      for (int i = 0; i < N_STIM; i++) begin
         run_one(int'(STIM[i][31:24]), STIM[i][23:8], STIM[i][7], STIM[i][6], BASE_A);
      end

      // R1: table at a second base; R2: exact fit and one byte short
      run_one(5, 16'h07FF, 1'b1, 1'b1, BASE_B);
      run_one(9, 16'h004F, 1'b1, 1'b0, BASE_A);
      run_one(9, 16'h004E, 1'b0, 1'b0, BASE_A);

      // R13: outputs hold after a completion
      run_one(1, 16'h07FF, 1'b1, 1'b0, BASE_A);
      s_sel = gate_sel; s_off = gate_off; s_kind = gate_kind; s_if = if_out;
      repeat (5) @(negedge clk);
      check({gate_sel, gate_off, gate_kind, if_out} === {s_sel, s_off, s_kind, s_if},
            "R13", "hold between pulses", 64'({gate_sel, gate_off, gate_kind, if_out}),
            64'({s_sel, s_off, s_kind, s_if}));

      // R10: requests while busy are ignored
      @(negedge clk);
      done_cnt = 0; rd_count = 0; stall_en = 1'b1;
      req_vector = 8'd2; tbl_limit = 16'h07FF; if_in = 1'b1; req_valid = 1'b1;
      @(negedge clk);
      req_vector = 8'd1; if_in = 1'b0;
      check(req_ready === 1'b0, "R10", "req_ready while busy", 64'(req_ready), 64'd0);
      repeat (3) @(negedge clk);
      req_valid = 1'b0;
      repeat (20) @(negedge clk);
      stall_en = 1'b0;
      check(done_cnt == 1, "R10", "completions", 64'(done_cnt), 64'd1);
      check(rd_count == 2, "R10", "reads", 64'(rd_count), 64'd2);
      check(gate_kind === 2'b11, "R10", "kind of first request", 64'(gate_kind), 64'd3);
      check(if_out === 1'b1, "R10", "flag of first request", 64'(if_out), 64'd1);

      // R11: reset in the middle of a fetch
      @(negedge clk);
      req_vector = 8'd33; tbl_limit = 16'h07FF; if_in = 1'b1; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      check(req_ready === 1'b1, "R11", "idle after mid reset", 64'(req_ready), 64'd1);
      check({done, gate_kind, gate_sel, gate_off, if_out} === '0, "R11",
            "cleared after mid reset", 64'({done, gate_kind, gate_sel, gate_off, if_out}), 64'd0);
      repeat (2) @(negedge clk);
      run_one(34, 16'h07FF, 1'b1, 1'b0, BASE_A);

      finish_run();
   end

endmodule